// File: doc/BRIEF.md
# External DMA Request Command Decoder

This block connects an external requesting device to a four-channel DMA controller. When the device asks for the data bus, the block grants it. After a fixed settling delay the block takes a command word from the data bus, qualified by a transfer-request strobe, and decodes it. The result is a one-cycle request pulse to one DMA channel. A channel-0 setting command also loads the command word into the channel-0 control register.

Two short-cut paths need no command phase. A strobe edge on its own, while the bus is idle, repeats a request to the channel that was requested last. A strobe edge that arrives together with a bus request goes straight to channel 2, and the bus is not granted. The block does not model the DMA engine, its address counters or the data movement.

Top module: `ext_dreq_decoder`

## Requirements
- R1: In the idle state, a cycle with bus_req_i high and xfer_stb_i low makes bus_avail_o go high after the next clock edge. A bus request seen while the bus is granted, including the release cycle, is ignored and does not start a new grant.
- R2: The command is sampled at the first clock edge where xfer_stb_i is high, counting from the second edge after bus_avail_o went high (GRANT_DLY = 2). A strobe before that edge is ignored. bus_avail_o stays high for the cycle after the sampling edge and is low after the edge that follows.
- R3: Command bits [1:0] carry the channel ID. A decoded request drives ch_req_o[ID] high in the cycle after the sampling edge.
- R4: A command with ID = 00 and bits [3:2] (mode) not 00 is a channel-0 setting. ch0_load_o pulses together with ch_req_o[0], and ch0_setting_o then shows the full sampled command word. ch0_setting_o keeps that value until the next load.
- R5: A command with ID = 00 and mode = 00 is a channel-0 bus handshake request. It produces a channel-0 pulse unless bits [6:4] (size) are 101 or 110. For those two values there is no pulse and the stored channel does not change.
- R6: In the idle state, a rising edge of xfer_stb_i with bus_req_i low pulses the stored channel in the next cycle, provided a channel has already been stored.
- R7: After reset no channel is stored. A strobe-only edge before the first request produces no pulse.
- R8: In the idle state, bus_req_i high together with a rising edge of xfer_stb_i pulses ch_req_o[2] in the next cycle. bus_avail_o stays low, and channel 2 becomes the stored channel.
- R9: Each request is a single-cycle pulse with at most one ch_req_o bit set. After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Data-bus request from the external device |
| xfer_stb_i | input | 1 | Transfer-request strobe |
| cmd_data_i | input | 32 | Data bus carrying the command word |
| bus_avail_o | output | 1 | Data bus granted to the device |
| ch_req_o | output | 4 | Per-channel DMA request pulses |
| ch0_load_o | output | 1 | Load strobe for the channel-0 control register |
| ch0_setting_o | output | 32 | Setting word for the channel-0 control register |

## Verification
Outputs change at the following cycles, with edge n being the edge that first sees a bus request:
- bus_avail_o is due one cycle after n.
- A decoded command pulse is due three cycles after n, at the sampling edge.
- bus_avail_o falls one cycle after that pulse.
- Strobe-only and direct requests pulse one cycle after the strobe edge.

The driver stamps each expected pulse with the exact cycle number at which it is due and pushes it into a queue. The monitor samples on falling clock edges, pops each pulse as it appears and compares its channel, load flag, setting word and cycle stamp. For rejected commands and strobe-only edges that must be ignored, the check reads ch_req_o exactly at the cycle where a pulse would otherwise have appeared.

// File: rtl/ext_dreq_pkg.sv
package ext_dreq_pkg;
  localparam int ID_LSB = 0;
  localparam int ID_W   = 2;
  localparam int MD_LSB = 2;
  localparam int MD_W   = 2;
  localparam int SZ_LSB = 4;
  localparam int SZ_W   = 3;
  localparam int CMD_W  = SZ_LSB + SZ_W;
  localparam int NUM_CH = 1 << ID_W;
  localparam logic [SZ_W-1:0] SZ_RSV_A = 3'b101;
  localparam logic [SZ_W-1:0] SZ_RSV_B = 3'b110;

  typedef enum logic [1:0] {
    GS_IDLE    = 2'd0,
    GS_GRANT   = 2'd1,
    GS_RELEASE = 2'd2
  } grant_state_e;
endpackage

// File: rtl/dreq_grant_fsm.sv
module dreq_grant_fsm
  import ext_dreq_pkg::*;
#(
  parameter int GRANT_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_req_i,
  input  logic xfer_stb_i,
  output logic bus_avail_o,
  output logic sample_o,
  output logic idle_o
);
  localparam int CNT_W = (GRANT_DLY > 1) ? $clog2(GRANT_DLY) : 1;

  grant_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GS_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        GS_IDLE: begin
          if (bus_req_i && !xfer_stb_i) begin
            state_q <= GS_GRANT;
            cnt_q   <= CNT_W'(GRANT_DLY - 1);
          end
        end
        GS_GRANT: begin
          if (cnt_q != '0)     cnt_q   <= cnt_q - 1'b1;
          else if (xfer_stb_i) state_q <= GS_RELEASE;
        end
        GS_RELEASE: state_q <= GS_IDLE;
        default:    state_q <= GS_IDLE;
      endcase
    end
  end

  assign bus_avail_o = (state_q != GS_IDLE);
  assign idle_o      = (state_q == GS_IDLE);
  assign sample_o    = (state_q == GS_GRANT) && (cnt_q == '0) && xfer_stb_i;

  p_grant_after_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_avail_o) |-> $past(bus_req_i && !xfer_stb_i));

  p_release_timing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> bus_avail_o ##1 !bus_avail_o);

  p_sample_in_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $past(bus_avail_o));
endmodule

// File: rtl/dreq_cmd_decode.sv
module dreq_cmd_decode
  import ext_dreq_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output logic             req_ok_o,
  output logic [ID_W-1:0]  chan_o,
  output logic             load_o
);
  logic [ID_W-1:0] id;
  logic [MD_W-1:0] md;
  logic [SZ_W-1:0] sz;
  logic            handshake;
  logic            sz_rsv;

  always_comb begin
    id        = cmd_i[ID_LSB +: ID_W];
    md        = cmd_i[MD_LSB +: MD_W];
    sz        = cmd_i[SZ_LSB +: SZ_W];
    handshake = (id == '0) && (md == '0);
    sz_rsv    = (sz == SZ_RSV_A) || (sz == SZ_RSV_B);
    req_ok_o  = !(handshake && sz_rsv);
    load_o    = (id == '0) && (md != '0);
    chan_o    = id;
  end
endmodule

// File: rtl/dreq_last_chan.sv
module dreq_last_chan #(
  parameter int CH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [CH_W-1:0] chan_i,
  output logic [CH_W-1:0] last_chan_o,
  output logic            last_vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_chan_o <= '0;
      last_vld_o  <= 1'b0;
    end else if (upd_i) begin
      last_chan_o <= chan_i;
      last_vld_o  <= 1'b1;
    end
  end

  p_store_update_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> last_vld_o && (last_chan_o == $past(chan_i)));

  p_vld_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_vld_o |=> last_vld_o);
endmodule

// File: rtl/ext_dreq_decoder.sv
module ext_dreq_decoder
  import ext_dreq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int GRANT_DLY = 2,
  parameter int DIRECT_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              xfer_stb_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              bus_avail_o,
  output logic [NUM_CH-1:0] ch_req_o,
  output logic              ch0_load_o,
  output logic [DATA_W-1:0] ch0_setting_o
);
  localparam int CH_W = ID_W;

  logic            sample, idle;
  logic            dec_ok, dec_load;
  logic [CH_W-1:0] dec_chan;
  logic [CH_W-1:0] last_chan;
  logic            last_vld;
  logic            stb_q, stb_rise;
  logic            fire_cmd, fire_direct, fire_repeat, fire;
  logic [CH_W-1:0] next_chan;
  logic [NUM_CH-1:0] ch_req_d;

  dreq_grant_fsm #(.GRANT_DLY(GRANT_DLY)) u_grant (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .xfer_stb_i  (xfer_stb_i),
    .bus_avail_o (bus_avail_o),
    .sample_o    (sample),
    .idle_o      (idle)
  );

  dreq_cmd_decode u_dec (
    .cmd_i    (cmd_data_i[CMD_W-1:0]),
    .req_ok_o (dec_ok),
    .chan_o   (dec_chan),
    .load_o   (dec_load)
  );

  dreq_last_chan #(.CH_W(CH_W)) u_last (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_i       (fire),
    .chan_i      (next_chan),
    .last_chan_o (last_chan),
    .last_vld_o  (last_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= xfer_stb_i;
  end

  assign stb_rise    = xfer_stb_i && !stb_q;
  assign fire_cmd    = sample && dec_ok;
  assign fire_direct = idle && bus_req_i && stb_rise;
  assign fire_repeat = idle && !bus_req_i && stb_rise && last_vld;
  assign fire        = fire_cmd || fire_direct || fire_repeat;

  always_comb begin
    if (fire_cmd)         next_chan = dec_chan;
    else if (fire_direct) next_chan = CH_W'(DIRECT_CH);
    else                  next_chan = last_chan;
  end

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_req
    assign ch_req_d[gi] = fire && (next_chan == CH_W'(gi));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_req_o      <= '0;
      ch0_load_o    <= 1'b0;
      ch0_setting_o <= '0;
    end else begin
      ch_req_o   <= ch_req_d;
      ch0_load_o <= fire_cmd && dec_load;
      if (fire_cmd && dec_load) ch0_setting_o <= cmd_data_i;
    end
  end

  p_onehot_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_req_o));

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_req_o != '0) |=> (ch_req_o == '0));

  p_load_with_ch0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch0_load_o |-> ch_req_o[0]);

  p_req_needs_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_req_o != '0) |-> last_vld);

  p_direct_no_grant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_req_o[DIRECT_CH] && !$past(bus_avail_o) && $past(bus_req_i)) |-> !bus_avail_o);
endmodule

// File: tb/ext_dreq_decoder_bench.sv
`timescale 1ns/1ps
module ext_dreq_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        stb = 1'b0;
  logic [31:0] data = '0;
  logic        avail;
  logic [3:0]  ch_req;
  logic        ld;
  logic [31:0] setting;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 1'b0;
  bit prev_nz = 1'b0;

  typedef struct {
    int          ch;
    bit          load;
    logic [31:0] data;
    int          due;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ext_dreq_decoder u_ext_dreq_decoder (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .bus_req_i     (bus_req),
    .xfer_stb_i    (stb),
    .cmd_data_i    (data),
    .bus_avail_o   (avail),
    .ch_req_o      (ch_req),
    .ch0_load_o    (ld),
    .ch0_setting_o (setting)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_nz && ch_req != 0) chk(1'b0, "R9 pulse longer than one cycle", ch_req, 0);
      if (ch_req != 0) begin
        if (q.size() == 0) chk(1'b0, "R9 unexpected request pulse", ch_req, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk($countones(ch_req) == 1, {e.tag, " R9 one channel"}, ch_req, 32'(1 << e.ch));
          chk(ch_req == 4'(1 << e.ch), {e.tag, " R3 channel"}, ch_req, 32'(1 << e.ch));
          chk(cyc == e.due, {e.tag, " R2 pulse cycle"}, cyc, e.due);
          chk(ld == e.load, {e.tag, " R4 load flag"}, ld, e.load);
          if (e.load) chk(setting == e.data, {e.tag, " R4 setting word"}, setting, e.data);
        end
      end else if (q.size() > 0 && q[0].due < cyc) begin
        exp_t m;
        m = q.pop_front();
        chk(1'b0, {m.tag, " missing pulse"}, 0, 32'(1 << m.ch));
      end
      prev_nz = (ch_req != 0);
    end
  end

  task automatic do_cmd(input logic [31:0] d, input int ch, input bit load, input string tag, input bit rereq);
    int n;
    @(negedge clk); bus_req = 1'b1; n = cyc;
    @(negedge clk); bus_req = 1'b0;
    chk(avail == 1'b1, "R1 grant after request", avail, 1);
    stb = 1'b1; data = d;  // strobe already high at the too-early edge n+2
    if (ch >= 0) q.push_back('{ch, load, d, n + 3, tag});
    @(negedge clk);
    chk(avail == 1'b1, "R2 bus held before sample", avail, 1);
    chk(ch_req == 0, "R2 no early sample", ch_req, 0);
    if (rereq) bus_req = 1'b1;
    @(negedge clk); stb = 1'b0;
    chk(avail == 1'b1, "R2 bus held in release cycle", avail, 1);
    if (ch < 0) chk(ch_req == 0, {tag, " rejected"}, ch_req, 0);
    @(negedge clk); bus_req = 1'b0;
    chk(avail == 1'b0, "R2 bus released", avail, 0);
    @(negedge clk);
    if (rereq) chk(avail == 1'b0, "R1 request during grant ignored", avail, 0);
  endtask

  task automatic strobe_only(input int ch, input string tag);
    int n;
    @(negedge clk); stb = 1'b1; n = cyc;
    if (ch >= 0) q.push_back('{ch, 1'b0, 32'h0, n + 1, tag});
    @(negedge clk); stb = 1'b0;
    if (ch < 0) chk(ch_req == 0, tag, ch_req, 0);
    @(negedge clk);
  endtask

  task automatic direct_req();
    int n;
    @(negedge clk); bus_req = 1'b1; stb = 1'b1; n = cyc;
    q.push_back('{2, 1'b0, 32'h0, n + 1, "R8 direct channel 2"});
    @(negedge clk); bus_req = 1'b0; stb = 1'b0;
    chk(avail == 1'b0, "R8 no grant on direct request", avail, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(avail == 1'b0, "R9 reset bus_avail", avail, 0);
    chk(ch_req == 0, "R9 reset ch_req", ch_req, 0);
    chk(ld == 1'b0, "R9 reset load", ld, 0);
    rst_n = 1'b1;
    @(negedge clk);

    strobe_only(-1, "R7 strobe before any request ignored");
    do_cmd(32'h1234_0001, 1, 1'b0, "R3 id=01", 1'b0);
    strobe_only(1, "R6 repeat channel 1");
    do_cmd(32'h0000_0F0B, 3, 1'b0, "R3 id=11 md=10", 1'b0);
    do_cmd(32'h0000_0050, -1, 1'b0, "R5 size 101 rejected", 1'b0);
    strobe_only(3, "R5 stored channel kept after rejection");
    do_cmd(32'h0000_0060, -1, 1'b0, "R5 size 110 rejected", 1'b0);
    do_cmd(32'h0000_0030, 0, 1'b0, "R5 handshake ch0 size 011", 1'b0);
    do_cmd(32'hCAFE_0034, 0, 1'b1, "R4 ch0 setting load", 1'b0);
    chk(setting == 32'hCAFE_0034, "R4 setting held", setting, 32'hCAFE_0034);
    direct_req();
    strobe_only(2, "R8 stored channel is 2 after direct");
    do_cmd(32'h0000_0002, 2, 1'b0, "R1 id=10 with re-request", 1'b1);
    do_cmd(32'h0000_0074, 0, 1'b1, "R4 setting mode ignores size", 1'b0);
    chk(setting == 32'h0000_0074, "R4 setting updated", setting, 32'h0000_0074);

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R3 all expected pulses seen", q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule